// File: doc/BRIEF.md
# Flow-Controlled Serial Panel Link

This block is the device side of a byte-wide serial link between a host controller and a control panel. The host owns the serial clock and both data lines, and no select line exists. Frames are eight clocks long, so byte boundaries are found by counting clock edges from reset. Each frame moves one byte in each direction. Bytes from the host are stored in a receive queue, where local logic reads them. On the same frame the block returns the next byte from a transmit queue that local logic fills. When that queue has nothing to give, a fixed idle byte is sent instead.

A separate acknowledge output tells the host whether it may keep sending. The output stays high while the receive queue has enough room left, and drops when an arriving byte uses up that room. Outgoing command bytes, those with the top bit set, get an extra marker bit when more transmit data is queued behind them. The serial inputs are sampled by the much faster system clock.

Top module: `spi_panel_link`

## Requirements
- R1: After reset, ack is 1, rx_empty and tx_empty are 1, rx_free and tx_free are both 64, and miso is 1.
- R2: The host sends bits least significant first. Each bit is placed on mosi while sck is low and is captured on the rising sck edge. Each group of eight rising edges forms one byte, which is appended to the receive queue.
- R3: The returned byte is sent least significant first. miso changes only after a falling sck edge and holds bit k of the byte between the k-th falling edge and the k-th rising edge of the frame.
- R4: The first four frames after reset return 0xFF, whatever the transmit queue holds.
- R5: If the transmit queue is empty when the next frame's byte is chosen (at the eighth rising edge of the previous frame), that frame returns 0xFF.
- R6: A byte taken from the transmit queue with bit 7 set is sent with bit 6 also set when at least one more byte remains queued behind it. Bytes with bit 7 clear, and the last queued byte, are sent unchanged.
- R7: ack equals 1 exactly when rx_free is at least 32. It drops when a received byte leaves fewer than 32 free entries and rises again once reads restore that room.
- R8: A byte arriving while the receive queue holds 64 bytes is dropped, and the queue is emptied: rx_empty becomes 1 and rx_free becomes 64.
- R9: rx_rd while rx_empty is 1 has no effect. tx_wr while tx_free is 0 has no effect, and the ignored byte is never sent.
- R10: Both queues are first-in first-out across pointer wrap-around. rx_data always shows the oldest unread byte, and rx_rd removes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host, idles high |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| ack | output | 1 | Flow-control acknowledge to host |
| rx_rd | input | 1 | Pop the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_empty | output | 1 | Receive queue empty |
| rx_free | output | 7 | Free receive entries |
| tx_wr | input | 1 | Push tx_wdata into the transmit queue |
| tx_wdata | input | 8 | Byte to queue for the host |
| tx_empty | output | 1 | Transmit queue empty |
| tx_free | output | 7 | Free transmit entries |

## Verification
The hardest state to reach is a full receive queue that then overflows. Reaching it needs 64 complete serial frames with no local reads. The stimulus gets there by draining a full transmit queue over 64 frames without reading the receive side. This also drives ack low at the 33rd byte, exercises end-mark tagging on a long run of command bytes, and moves both pointers past the wrap point. One more frame then triggers the overflow, and a later partial fill followed by reads shows ack coming back.

// File: rtl/spi_panel_link.sv
module spi_panel_link #(
  parameter int DEPTH = 64,
  parameter int ACK_ROOM = 32,
  parameter logic [7:0] IDLE_BYTE = 8'hFF,
  parameter int PRELOAD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       mosi,
  output logic       miso,
  output logic       ack,
  input  logic       rx_rd,
  output logic [7:0] rx_data,
  output logic       rx_empty,
  output logic [6:0] rx_free,
  input  logic       tx_wr,
  input  logic [7:0] tx_wdata,
  output logic       tx_empty,
  output logic [6:0] tx_free
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int PW = $clog2(PRELOAD + 1);

  logic [2:0] sck_s;
  logic [1:0] mosi_s;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] cur_tx;
  logic [PW-1:0] pre_cnt;

  wire sck_rise = sck_s[1] & ~sck_s[2];
  wire sck_fall = ~sck_s[1] & sck_s[2];
  wire byte_done = sck_rise && (bit_cnt == 3'd7);
  wire [7:0] rx_byte = {mosi_s[1], rx_sh};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s   <= 3'b111;
      mosi_s  <= 2'b00;
      bit_cnt <= '0;
      rx_sh   <= '0;
      miso    <= 1'b1;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      mosi_s <= {mosi_s[0], mosi};
      if (sck_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sh   <= {mosi_s[1], rx_sh[6:1]};
      end
      if (sck_fall) miso <= cur_tx[bit_cnt];
    end

  // receive queue
  logic [7:0] rx_mem [DEPTH];
  logic [CW-1:0] rx_wp, rx_rp, rx_cnt, rx_cnt_nx;
  assign rx_cnt = rx_wp - rx_rp;
  wire rx_full = rx_cnt == CW'(DEPTH);
  wire rx_ovf  = byte_done & rx_full;
  wire rx_pop  = rx_rd & ~rx_empty;
  assign rx_empty = rx_cnt == '0;
  assign rx_free  = 7'(CW'(DEPTH) - rx_cnt);
  assign rx_data  = rx_mem[rx_rp[AW-1:0]];

  always_comb
    if (rx_ovf) rx_cnt_nx = '0;
    else rx_cnt_nx = rx_cnt + CW'(byte_done) - CW'(rx_pop);

  always_ff @(posedge clk)
    if (byte_done && !rx_full) rx_mem[rx_wp[AW-1:0]] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0;
      rx_rp <= '0;
      ack   <= 1'b1;
    end else begin
      if (rx_ovf) begin
        rx_wp <= '0;
        rx_rp <= '0;
      end else begin
        if (byte_done) rx_wp <= rx_wp + 1'b1;
        if (rx_pop) rx_rp <= rx_rp + 1'b1;
      end
      ack <= (CW'(DEPTH) - rx_cnt_nx) >= CW'(ACK_ROOM);
    end

  // transmit queue
  logic [7:0] tx_mem [DEPTH];
  logic [CW-1:0] tx_wp, tx_rp, tx_cnt;
  assign tx_cnt = tx_wp - tx_rp;
  wire tx_push = tx_wr && (tx_cnt != CW'(DEPTH));
  wire tx_take = byte_done && (pre_cnt == '0) && (tx_cnt != '0);
  wire [7:0] tx_head = tx_mem[tx_rp[AW-1:0]];
  wire [7:0] tx_tagged = (tx_head[7] && tx_cnt > CW'(1)) ? (tx_head | 8'h40) : tx_head;
  assign tx_empty = tx_cnt == '0;
  assign tx_free  = 7'(CW'(DEPTH) - tx_cnt);

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp[AW-1:0]] <= tx_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp   <= '0;
      tx_rp   <= '0;
      cur_tx  <= IDLE_BYTE;
      pre_cnt <= PW'(PRELOAD - 1);
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_take) tx_rp <= tx_rp + 1'b1;
      if (byte_done) begin
        if (pre_cnt != '0) begin
          pre_cnt <= pre_cnt - 1'b1;
          cur_tx  <= IDLE_BYTE;
        end else cur_tx <= tx_take ? tx_tagged : IDLE_BYTE;
      end
    end
endmodule

// File: rtl/spi_panel_link_chk.sv
module spi_panel_link_chk #(
  parameter int DEPTH = 64,
  parameter int ACK_ROOM = 32,
  parameter logic [7:0] IDLE_BYTE = 8'hFF
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       miso,
  input logic       rx_rd,
  input logic       rx_empty,
  input logic [6:0] rx_free,
  input logic       tx_wr,
  input logic       tx_empty,
  input logic [6:0] tx_free,
  input logic       byte_done,
  input logic       sck_fall,
  input logic [7:0] cur_tx
);
  a_r7_ack_room: assert property (@(posedge clk) disable iff (!rst_n)
    ack == (32'(rx_free) >= ACK_ROOM));
  a_r8_overflow_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && rx_free == 7'd0) |=> (rx_empty && 32'(rx_free) == DEPTH));
  a_r9_rx_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && rx_rd && !byte_done) |=> rx_empty);
  a_r9_tx_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_free == 7'd0 && tx_wr && !byte_done) |=> tx_free == 7'd0);
  a_r5_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && tx_empty) |=> cur_tx == IDLE_BYTE);
  a_r3_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(miso));
endmodule

bind spi_panel_link spi_panel_link_chk #(.DEPTH(DEPTH), .ACK_ROOM(ACK_ROOM), .IDLE_BYTE(IDLE_BYTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .miso(miso), .rx_rd(rx_rd),
  .rx_empty(rx_empty), .rx_free(rx_free), .tx_wr(tx_wr), .tx_empty(tx_empty),
  .tx_free(tx_free), .byte_done(byte_done), .sck_fall(sck_fall), .cur_tx(cur_tx)
);

// File: tb/tb_spi_panel_link.sv
module tb_spi_panel_link;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK = 8;

  logic clk = 0, rst_n = 0, sck = 1, mosi = 0, rx_rd = 0, tx_wr = 0;
  logic [7:0] tx_wdata = 0;
  logic miso, ack, rx_empty, tx_empty;
  logic [7:0] rx_data;
  logic [6:0] rx_free, tx_free;

  spi_panel_link dut (.clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .miso(miso),
    .ack(ack), .rx_rd(rx_rd), .rx_data(rx_data), .rx_empty(rx_empty), .rx_free(rx_free),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_empty(tx_empty), .tx_free(tx_free));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit settled = 0;
  byte unsigned rxq[$], txq[$];
  byte unsigned next_out = 8'hFF;
  int pre = 3;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (settled && rst_n) begin
    chk(ack == ((64 - rxq.size()) >= 32), "R7", "ack", ack, (64 - rxq.size()) >= 32);
    chk(rx_free == 7'(64 - rxq.size()), "R8", "rx_free", rx_free, 64 - rxq.size());
    chk(rx_empty == (rxq.size() == 0), "R8", "rx_empty", rx_empty, rxq.size() == 0);
    chk(tx_free == 7'(64 - txq.size()), "R9", "tx_free", tx_free, 64 - txq.size());
    chk(tx_empty == (txq.size() == 0), "R9", "tx_empty", tx_empty, txq.size() == 0);
    if (rxq.size() != 0) chk(rx_data == rxq[0], "R10", "rx_data", rx_data, rxq[0]);
  end

  // one host frame; alignment relies only on counting rising edges (R2, R3)
  task automatic xfer(input byte unsigned b);
    byte unsigned got;
    settled = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #2; sck = 0; mosi = b[i];
      repeat (HALF_SCK) @(posedge clk);
      #2; got[i] = miso; sck = 1;
      repeat (HALF_SCK) @(posedge clk);
    end
    repeat (6) @(posedge clk);
    #2;
    chk(got == next_out, "R3", "miso byte", got, next_out);
    if (rxq.size() == 64) rxq.delete(); else rxq.push_back(b);
    if (pre > 0) begin next_out = 8'hFF; pre--; end
    else if (txq.size() == 0) next_out = 8'hFF;
    else begin
      next_out = txq.pop_front();
      if (next_out[7] && txq.size() > 0) next_out |= 8'h40;
    end
    settled = 1;
  endtask

  task automatic tx_write(input byte unsigned d);
    @(posedge clk); #2; tx_wr = 1; tx_wdata = d;
    @(posedge clk); #2; tx_wr = 0;
    if (txq.size() < 64) txq.push_back(d);
  endtask

  task automatic rx_read();
    @(posedge clk); #2; rx_rd = 1;
    @(posedge clk); #2; rx_rd = 0;
    if (rxq.size() > 0) void'(rxq.pop_front());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "WDOG", "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #2; rst_n = 1;
    repeat (2) @(posedge clk); #2;
    // R1 reset state
    chk(ack == 1, "R1", "ack", ack, 1);
    chk(rx_empty == 1 && tx_empty == 1, "R1", "empties", {rx_empty, tx_empty}, 3);
    chk(rx_free == 64 && tx_free == 64, "R1", "free", rx_free, 64);
    chk(miso == 1, "R1", "miso", miso, 1);
    settled = 1;

    // R4 preload frames idle even with queued data, then R6 tagging
    tx_write(8'h81); tx_write(8'h82);
    xfer(8'h11); xfer(8'hA5); xfer(8'h3C); xfer(8'h00);
    chk(next_out == 8'hC1, "R6", "model tag", next_out, 8'hC1);
    xfer(8'hFF); xfer(8'h5A);
    // R5 empty queue gives idle
    xfer(8'h96);
    chk(next_out == 8'hFF, "R5", "idle next", next_out, 8'hFF);
    xfer(8'h01);

    // R2 host bytes come out in order
    for (int i = 0; i < 8; i++) begin
      chk(rx_data == rxq[0], "R2", "rx byte", rx_data, rxq[0]);
      rx_read();
    end
    // R9 read when empty is ignored
    chk(rx_empty == 1, "R9", "rx_empty before", rx_empty, 1);
    rx_read();
    chk(rx_empty == 1 && rx_free == 64, "R9", "rx after empty read", rx_free, 64);

    // R6 mixed bytes
    tx_write(8'h05); tx_write(8'h90); tx_write(8'h7F);
    xfer(8'h21); xfer(8'h22); xfer(8'h23); xfer(8'h24);
    while (rxq.size() > 0) rx_read();

    // R9 fill transmit queue and try one extra
    for (int i = 0; i < 65; i++) tx_write(8'((i * 37 + 5) | ((i % 3 == 0) ? 8'h80 : 8'h00)));
    chk(tx_free == 0, "R9", "tx_free full", tx_free, 0);

    // drain: 64 host bytes fill rx, ack falls at the 33rd (R7), wrap-around (R10)
    for (int i = 0; i < 64; i++) begin
      xfer(8'(i * 11 + 3));
      if (i == 31) chk(ack == 1, "R7", "ack at 32 used", ack, 1);
      if (i == 32) chk(ack == 0, "R7", "ack at 33 used", ack, 0);
    end
    chk(rx_free == 0, "R8", "rx full", rx_free, 0);
    // R8 overflow empties
    xfer(8'hEE);
    chk(rx_empty == 1 && rx_free == 64, "R8", "after overflow", rx_free, 64);
    chk(ack == 1, "R7", "ack after overflow", ack, 1);
    // R9 ignored extra byte never sent
    xfer(8'h44);
    chk(next_out == 8'hFF, "R9", "no extra tx byte", next_out, 8'hFF);

    // R7 ack recovery by reads
    for (int i = 0; i < 39; i++) xfer(8'(i + 100));
    chk(ack == 0, "R7", "ack low at 40 used", ack, 0);
    for (int i = 0; i < 8; i++) rx_read();
    chk(ack == 1, "R7", "ack back at 32 free", ack, 1);
    chk(rx_data == rxq[0], "R10", "oldest after wrap", rx_data, rxq[0]);
    while (rxq.size() > 0) rx_read();
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule